// File: doc/BRIEF.md
# NAND Read Data Output Sequencer

This block produces the words seen on the read side of a NAND device's data bus. A separate command decoder tells it which read mode is active, and the block then answers each read strobe from one of three sources. In ID mode it steps through four identification bytes. In status mode it returns the live status byte. In page mode it streams words from a page buffer that an external array loads on request. The block tracks a buffer pointer, a column address, a one-shot column offset and a remaining-length count, so the buffer and the array themselves stay outside it.

In page mode, a strobe that finds the buffer empty does not fail. It raises a one-cycle load request for the column plus the stored offset, clears the offset, and holds the ready/busy line low. When the array reports completion, the block serves the deferred read on the following cycle. The bus can be 8 or 16 bits wide, selected at run time. In 8-bit mode the upper half of the output word is always zero.

Top module: `nand_rdout_seq`

## Requirements
- R1: After reset the output word is zero, ready/busy is high, no load is requested, and the block is in page mode (code 0) with column, offset and length zero, so the first accepted strobe requests a load at address 0.
- R2: The status byte has these fields. Bit 0 is the error flag and bits 4:1 are the plane flags, both taken from `sts_bits_i[4:0]` when `sts_upd_i` pulses. Bit 5 is zero. Bit 6 is 1 unless a load is pending. Bit 7 equals the `wp_n_i` level in the cycle of the read.
- R3: In status mode (code 2), every accepted strobe returns the current status byte, and neither the buffer pointer nor the remaining length moves until a new command arrives.
- R4: After an ID command (code 1), four accepted strobes return `MFR_ID`, then `DEV_ID`, then `FILL_ID`, then a page-type byte. The page-type byte is 0x55 when `large_page_i` and `bus16_i` are both 1, 0x15 when `large_page_i` is 1 and `bus16_i` is 0, and 0xC0 when `large_page_i` is 0. Every later strobe returns zero.
- R5: ID and status bytes appear on bits 7:0 with bits 15:8 zero. Page data is the full `buf_data_i` word when `bus16_i` is 1, and only its low byte (upper byte zero) when `bus16_i` is 0.
- R6: In page mode (code 0), a strobe accepted with zero remaining length and no load pending does four things. It raises `load_req_o` for exactly one cycle, sets `load_addr_o` to column plus offset, clears the offset, and drives `rb_o` low until `load_done_i`.
- R7: A pending read is served in the cycle after `load_done_i`, starting from buffer byte address 0. Each page word served moves the pointer and the column forward by the bus width in bytes (1 or 2), and the remaining length goes down by the same amount, stopping at zero.
- R8: A clock edge with `ce_n_i` high leaves the output at zero, and strobes during that time are ignored.
- R9: A page read with no data to return outputs zero. This covers a completed load of length zero, and also the strobe that requests a new load once the buffer is exhausted. That new load starts at the advanced column.
- R10: In page mode, strobes that arrive while a load is pending are ignored. They neither request again nor advance.
- R11: The output word changes at the first clock edge that samples an accepted strobe.
- R12: If a status update and a status read fall on the same edge, that read returns the old error and plane flags, and the next read returns the new ones.
- R13: In the idle mode (code 3), accepted strobes return zero. A strobe in the same cycle as `cmd_valid_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle pulse: a new command takes effect |
| cmd_code_i | input | 2 | 0 page read, 1 read ID, 2 read status, 3 idle |
| col_i | input | ADDR_W | Column address loaded with a page command |
| off_i | input | ADDR_W | One-shot column offset loaded with a page command |
| bus16_i | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| large_page_i | input | 1 | Device has large pages (selects the last ID byte) |
| wp_n_i | input | 1 | Write-protect pin, low means protected |
| ce_n_i | input | 1 | Chip enable, active low |
| re_i | input | 1 | Read strobe, one pulse per word |
| sts_upd_i | input | 1 | Capture new error and plane flags |
| sts_bits_i | input | 5 | Error (bit 0) and plane flags (bits 4:1) |
| load_done_i | input | 1 | Array finished the requested page load |
| load_len_i | input | ADDR_W | Bytes available in the buffer after the load |
| buf_data_i | input | 16 | Buffer word at `buf_addr_o` (byte addr in 7:0, next byte in 15:8) |
| buf_addr_o | output | ADDR_W | Buffer byte pointer |
| load_req_o | output | 1 | One-cycle page load request |
| load_addr_o | output | ADDR_W | Column at which the load starts |
| dout_o | output | 16 | Registered read data word |
| rb_o | output | 1 | Ready/busy, low while a load is pending |

## Verification
Two things can happen on the same clock edge: a status read, and a status update that rewrites the error and plane flags. The bench raises `sts_upd_i` in the same cycle as the read strobe. It expects the old flags from that read and the new flags from the next one. A second coincidence also needs care. A strobe that arrives while a page load is in flight must not add an advance to the deferred read served after `load_done_i`. The bench checks this by confirming that the served stream still starts at buffer byte 0 and that the follow-up load address reflects exactly the number of words delivered.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [1:0] {
        MODE_PAGE  = 2'd0,
        MODE_ID    = 2'd1,
        MODE_STAT  = 2'd2,
        MODE_OTHER = 2'd3
    } nrd_mode_e;

    localparam int ID_BYTES = 4;

endpackage

// File: rtl/nrd_status.sv
module nrd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_i,
    input  logic [4:0] bits_i,
    input  logic       busy_i,
    input  logic       wp_n_i,
    output logic [7:0] status_o
);

    typedef struct packed {
        logic [4:0] flags;
    } sts_t;

    sts_t sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (upd_i) begin
            sts_d.flags = bits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    // pin level and load state are folded in at read time
    assign status_o = {wp_n_i, ~busy_i, 1'b0, sts_q.flags};

    assert_flags_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> status_o[4:0] == $past(bits_i));

    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(status_o[4:0]));

endmodule

// File: rtl/nrd_idgen.sv
module nrd_idgen #(
    parameter logic [7:0] MFR_ID  = 8'hEC,
    parameter logic [7:0] DEV_ID  = 8'hDA,
    parameter logic [7:0] FILL_ID = 8'hA5
) (
    input  logic [1:0] idx_i,
    input  logic       large_i,
    input  logic       wide_i,
    output logic [7:0] byte_o
);

    logic [7:0] geom;

    always_comb begin
        if (!large_i) begin
            geom = 8'hC0;
        end else if (wide_i) begin
            geom = 8'h55;
        end else begin
            geom = 8'h15;
        end
    end

    always_comb begin
        unique case (idx_i)
            2'd0:    byte_o = MFR_ID;
            2'd1:    byte_o = DEV_ID;
            2'd2:    byte_o = FILL_ID;
            default: byte_o = geom;
        endcase
    end

endmodule

// File: rtl/nrd_cursor.sv
module nrd_cursor #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_i,
    input  logic              page_i,
    input  logic [ADDR_W-1:0] col_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic              req_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] done_len_i,
    input  logic              adv_i,
    input  logic [1:0]        step_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [ADDR_W-1:0] len_o,
    output logic              pending_o,
    output logic              owed_o,
    output logic              load_req_o,
    output logic [ADDR_W-1:0] load_addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic              owed;
        logic              req;
    } cur_t;

    cur_t cur_d, cur_q;
    logic [ADDR_W-1:0] step_x;

    assign step_x = {{(ADDR_W-2){1'b0}}, step_i};

    always_comb begin
        cur_d     = cur_q;
        cur_d.req = 1'b0;
        // a deferred read is served by the parent in this very cycle
        if (cur_q.owed && !cur_q.pend) begin
            cur_d.owed = 1'b0;
        end
        if (adv_i) begin
            cur_d.ptr = cur_q.ptr + step_x;
            cur_d.col = cur_q.col + step_x;
            cur_d.len = (cur_q.len > step_x) ? (cur_q.len - step_x) : '0;
        end
        if (done_i) begin
            cur_d.pend = 1'b0;
            cur_d.len  = done_len_i;
            cur_d.ptr  = '0;
        end
        if (req_i) begin
            cur_d.pend = 1'b1;
            cur_d.req  = 1'b1;
            cur_d.addr = cur_q.col + cur_q.off;
            cur_d.off  = '0;
            cur_d.owed = 1'b1;
        end
        if (cmd_i) begin
            cur_d.owed = 1'b0;
            if (page_i) begin
                cur_d.col = col_i;
                cur_d.off = off_i;
                cur_d.len = '0;
                cur_d.ptr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign ptr_o       = cur_q.ptr;
    assign len_o       = cur_q.len;
    assign pending_o   = cur_q.pend;
    assign owed_o      = cur_q.owed;
    assign load_req_o  = cur_q.req;
    assign load_addr_o = cur_q.addr;

    assert_len_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> cur_q.len <= $past(cur_q.len));

    assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.req |-> cur_q.pend);

    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.req |=> !cur_q.req);

    assert_offset_spent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.req |-> cur_q.off == '0);

endmodule

// File: rtl/nand_rdout_seq.sv
module nand_rdout_seq
    import nrd_pkg::*;
#(
    parameter int         PAGE_BYTES  = 2048,
    parameter int         SPARE_BYTES = 64,
    parameter logic [7:0] MFR_ID      = 8'hEC,
    parameter logic [7:0] DEV_ID      = 8'hDA,
    parameter logic [7:0] FILL_ID     = 8'hA5,
    localparam int        ADDR_W      = $clog2(PAGE_BYTES + SPARE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_code_i,
    input  logic [ADDR_W-1:0] col_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic              bus16_i,
    input  logic              large_page_i,
    input  logic              wp_n_i,
    input  logic              ce_n_i,
    input  logic              re_i,
    input  logic              sts_upd_i,
    input  logic [4:0]        sts_bits_i,
    input  logic              load_done_i,
    input  logic [ADDR_W-1:0] load_len_i,
    input  logic [15:0]       buf_data_i,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic              load_req_o,
    output logic [ADDR_W-1:0] load_addr_o,
    output logic [15:0]       dout_o,
    output logic              rb_o
);

    localparam int IDX_W = $clog2(ID_BYTES) + 1;

    typedef struct packed {
        nrd_mode_e        mode;
        logic [IDX_W-1:0] idx;
        logic [15:0]      dout;
    } top_t;

    top_t top_d, top_q;

    logic              rd_ok;
    logic              serve;
    logic              adv;
    logic              req;
    logic [1:0]        step;
    logic [15:0]       word;
    logic [7:0]        id_byte;
    logic [7:0]        status;
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] cur_len;
    logic              pend;
    logic              owed;

    assign rd_ok = re_i && !ce_n_i && !cmd_valid_i;
    assign serve = owed && !pend;
    assign step  = bus16_i ? 2'd2 : 2'd1;
    assign word  = bus16_i ? buf_data_i : {8'h00, buf_data_i[7:0]};

    nrd_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_valid_i),
        .page_i     (cmd_code_i == MODE_PAGE),
        .col_i      (col_i),
        .off_i      (off_i),
        .req_i      (req),
        .done_i     (load_done_i),
        .done_len_i (load_len_i),
        .adv_i      (adv),
        .step_i     (step),
        .ptr_o      (cur_ptr),
        .len_o      (cur_len),
        .pending_o  (pend),
        .owed_o     (owed),
        .load_req_o (load_req_o),
        .load_addr_o(load_addr_o)
    );

    nrd_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (sts_upd_i),
        .bits_i  (sts_bits_i),
        .busy_i  (pend),
        .wp_n_i  (wp_n_i),
        .status_o(status)
    );

    nrd_idgen #(
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID),
        .FILL_ID(FILL_ID)
    ) u_idgen (
        .idx_i  (top_q.idx[1:0]),
        .large_i(large_page_i),
        .wide_i (bus16_i),
        .byte_o (id_byte)
    );

    always_comb begin
        top_d = top_q;
        adv   = 1'b0;
        req   = 1'b0;

        if (cmd_valid_i) begin
            top_d.mode = nrd_mode_e'(cmd_code_i);
            top_d.idx  = '0;
        end

        unique case (top_q.mode)
            MODE_PAGE: begin
                if (serve && !cmd_valid_i) begin
                    if (cur_len != '0) begin
                        top_d.dout = word;
                        adv        = 1'b1;
                    end else begin
                        top_d.dout = '0;
                    end
                end else if (rd_ok && !pend && !owed) begin
                    if (cur_len != '0) begin
                        top_d.dout = word;
                        adv        = 1'b1;
                    end else begin
                        top_d.dout = '0;
                        req        = 1'b1;
                    end
                end
            end
            MODE_ID: begin
                if (rd_ok) begin
                    if (top_q.idx < IDX_W'(ID_BYTES)) begin
                        top_d.dout = {8'h00, id_byte};
                        top_d.idx  = top_q.idx + 1'b1;
                    end else begin
                        top_d.dout = '0;
                    end
                end
            end
            MODE_STAT: begin
                if (rd_ok) begin
                    top_d.dout = {8'h00, status};
                end
            end
            default: begin
                if (rd_ok) begin
                    top_d.dout = '0;
                end
            end
        endcase

        if (ce_n_i) begin
            top_d.dout = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{mode: MODE_PAGE, idx: '0, dout: '0};
        end else begin
            top_q <= top_d;
        end
    end

    assign dout_o     = top_q.dout;
    assign rb_o       = ~pend;
    assign buf_addr_o = cur_ptr;

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |=> dout_o == '0);

    assert_busy_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> !rb_o);

    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !bus16_i) |=> dout_o[15:8] == 8'h00);

    assert_status_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.mode == MODE_STAT && !cmd_valid_i && !load_done_i) |=> $stable(buf_addr_o));

    assert_id_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.mode == MODE_ID && top_q.idx == IDX_W'(ID_BYTES) && rd_ok) |=> dout_o == '0);

endmodule

// File: tb/nand_rdout_seq_test.sv
module nand_rdout_seq_test;

    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [1:0]    cmd_code;
    logic [AW-1:0] col;
    logic [AW-1:0] off;
    logic          bus16;
    logic          large_page;
    logic          wp_n;
    logic          ce_n;
    logic          re;
    logic          sts_upd;
    logic [4:0]    sts_bits;
    logic          load_done;
    logic [AW-1:0] load_len;
    logic [15:0]   buf_data;
    logic [AW-1:0] buf_addr;
    logic          load_req;
    logic [AW-1:0] load_addr;
    logic [15:0]   dout;
    logic          rb;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] bb(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd7 + 8'd3);
    endfunction

    assign buf_data = {bb(buf_addr + 13'd1), bb(buf_addr)};

    nand_rdout_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .col_i(col), .off_i(off), .bus16_i(bus16), .large_page_i(large_page),
        .wp_n_i(wp_n), .ce_n_i(ce_n), .re_i(re), .sts_upd_i(sts_upd),
        .sts_bits_i(sts_bits), .load_done_i(load_done), .load_len_i(load_len),
        .buf_data_i(buf_data), .buf_addr_o(buf_addr), .load_req_o(load_req),
        .load_addr_o(load_addr), .dout_o(dout), .rb_o(rb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd();
        re = 1'b1;
        cyc();
        re = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] code, input logic [AW-1:0] c, input logic [AW-1:0] o);
        cmd_valid = 1'b1;
        cmd_code  = code;
        col       = c;
        off       = o;
        cyc();
        cmd_valid = 1'b0;
    endtask

    task automatic finish_load(input logic [AW-1:0] n);
        load_done = 1'b1;
        load_len  = n;
        cyc();
        load_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dout", 32'(dout), 32'h0);
        chk("R1 rb", 32'(rb), 32'h1);
        chk("R1 load_req", 32'(load_req), 32'h0);
        rd();
        chk("R1 first load_req", 32'(load_req), 32'h1);
        chk("R1 first load_addr", 32'(load_addr), 32'h0);
        finish_load('0);
        cyc();
        chk("R9 empty load", 32'(dout), 32'h0);
    endtask

    task automatic t_page8();
        bus16 = 1'b0;
        cmd(2'd0, 13'd4, 13'd0);
        rd();
        chk("R6 req", 32'(load_req), 32'h1);
        chk("R6 addr", 32'(load_addr), 32'd4);
        chk("R6 busy", 32'(rb), 32'h0);
        rd();
        chk("R10 no re-request", 32'(load_req), 32'h0);
        chk("R10 still busy", 32'(rb), 32'h0);
        finish_load(13'd5);
        chk("R6 ready after done", 32'(rb), 32'h1);
        cyc();
        chk("R7 served byte0", 32'(dout), 32'({8'h00, bb(13'd0)}));
        for (int i = 1; i < 5; i++) begin
            rd();
            chk("R7 stream8", 32'(dout), 32'({8'h00, bb(13'(i))}));
        end
        rd();
        chk("R9 exhausted zero", 32'(dout), 32'h0);
        chk("R9 advanced column", 32'(load_addr), 32'd9);
        finish_load('0);
        cyc();
    endtask

    task automatic t_page16();
        bus16 = 1'b1;
        cmd(2'd0, 13'd2, 13'h100);
        rd();
        chk("R6 col plus offset", 32'(load_addr), 32'h102);
        finish_load(13'd4);
        cyc();
        chk("R5 wide word0", 32'(dout), 32'({bb(13'd1), bb(13'd0)}));
        rd();
        chk("R7 wide word1", 32'(dout), 32'({bb(13'd3), bb(13'd2)}));
        rd();
        chk("R6 offset cleared", 32'(load_addr), 32'd6);
        finish_load('0);
        cyc();
        bus16 = 1'b0;
    endtask

    task automatic t_status();
        sts_upd  = 1'b1;
        sts_bits = 5'b10110;
        cyc();
        sts_upd  = 1'b0;
        cmd(2'd0, 13'd0, 13'd0);
        rd();
        cmd(2'd2, 13'd0, 13'd0);
        rd();
        chk("R2 busy status", 32'(dout), 32'h96);
        finish_load(13'd3);
        cyc();
        rd();
        chk("R2 ready status", 32'(dout), 32'hD6);
        wp_n = 1'b0;
        rd();
        chk("R2 protected status", 32'(dout), 32'h56);
        rd();
        chk("R3 repeat status", 32'(dout), 32'h56);
        bus16 = 1'b1;
        rd();
        chk("R5 wide status", 32'(dout), 32'h0056);
        bus16 = 1'b0;
        wp_n  = 1'b1;
    endtask

    task automatic t_coincide();
        cmd(2'd2, 13'd0, 13'd0);
        sts_upd  = 1'b1;
        sts_bits = 5'b00001;
        re       = 1'b1;
        cyc();
        sts_upd  = 1'b0;
        re       = 1'b0;
        chk("R12 old flags", 32'(dout), 32'hD6);
        rd();
        chk("R12 new flags", 32'(dout), 32'hC1);
    endtask

    task automatic t_id();
        bus16      = 1'b0;
        large_page = 1'b0;
        cmd(2'd1, 13'd0, 13'd0);
        re = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 one clock", 32'(dout), 32'h00EC);
        @(negedge clk);
        re = 1'b0;
        rd();
        chk("R4 dev", 32'(dout), 32'h00DA);
        rd();
        chk("R4 fill", 32'(dout), 32'h00A5);
        rd();
        chk("R4 small page", 32'(dout), 32'h00C0);
        rd();
        chk("R4 past end", 32'(dout), 32'h0);
        bus16      = 1'b1;
        large_page = 1'b1;
        cmd(2'd1, 13'd0, 13'd0);
        for (int i = 0; i < 3; i++) rd();
        rd();
        chk("R4 large wide", 32'(dout), 32'h0055);
        bus16 = 1'b0;
        cmd(2'd1, 13'd0, 13'd0);
        for (int i = 0; i < 3; i++) rd();
        rd();
        chk("R4 large narrow", 32'(dout), 32'h0015);
        large_page = 1'b0;
    endtask

    task automatic t_ce();
        cmd(2'd1, 13'd0, 13'd0);
        ce_n = 1'b1;
        rd();
        chk("R8 zero when off", 32'(dout), 32'h0);
        ce_n = 1'b0;
        rd();
        chk("R8 strobe ignored", 32'(dout), 32'h00EC);
        ce_n = 1'b1;
        cyc();
        chk("R8 cleared", 32'(dout), 32'h0);
        ce_n = 1'b0;
    endtask

    task automatic t_other();
        cmd(2'd1, 13'd0, 13'd0);
        rd();
        chk("R13 pre", 32'(dout), 32'h00EC);
        cmd(2'd3, 13'd0, 13'd0);
        rd();
        chk("R13 idle zero", 32'(dout), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 2'd0; col = '0; off = '0;
        bus16 = 1'b0; large_page = 1'b0; wp_n = 1'b1; ce_n = 1'b0; re = 1'b0;
        sts_upd = 1'b0; sts_bits = '0; load_done = 1'b0; load_len = '0;
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_page8();
        t_page16();
        t_status();
        t_coincide();
        t_id();
        t_ce();
        t_other();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule